// File: doc/BRIEF.md
# Pair-Load Address and Writeback Sequencer

The block takes a 32-bit load-pair instruction word and runs the load from start to finish. It decodes one of three addressing classes and reads the base value, which comes from a general register or from the stack pointer. It forms the effective address from that base and a scaled signed offset. It then issues one 256-bit read request on a valid/ready memory channel.

When the response comes back, the block splits it into two 128-bit vector register writes and can also write the updated address back to the base. The order of the two halves depends on the endianness input. A destination pair that names the same register twice is handled by a policy chosen at run time.

The block sits in the load path of a vector unit. Instructions are offered with a valid signal and are taken only while `ins_ready` is high. Decode errors and alignment errors are reported as one-cycle pulses, and neither one starts a memory access.

Top module: `pairld_seq`

## Requirements
- R1: Bits [31:22] of the instruction word select the class: 1110110011 is post-index, 1110110111 is pre-index and 1110110101 is signed-offset. Any other value pulses `undef_o` for one cycle, starting in the cycle after acceptance, and issues no request and no write.
- R2: Fields are decoded as imm7 = [21:15], Rt2 = [14:10], Rn = [9:5] and Rt = [4:0]. The byte offset is imm7 sign-extended and multiplied by 16, so it spans -1024 to +1008.
- R3: The request address is base+offset for the pre-index and signed-offset classes. For post-index it is the unmodified base.
- R4: Pre-index and post-index write base+offset back to the base. Signed-offset raises no base write.
- R5: When Rn = 31, the base is `sp_rdata` instead of the general register read. The writeback then sets `wb_to_sp` with `wb_idx` = 31.
- R6: When Rn = 31 and `sp_rdata[3:0]` is not zero, `align_fault_o` pulses for one cycle. No request and no write follow.
- R7: With `big_endian` low, Rt receives response bits [127:0] on port 0 and Rt2 receives bits [255:128] on port 1. With `big_endian` high, Rt receives [255:128] and Rt2 receives [127:0].
- R8: When Rt = Rt2, `ovl_mode` chooses the outcome. A value of 0 (or 3) raises undefined. A value of 1 makes the instruction a no-op with no output activity. A value of 2 performs the load, writes the fill pattern (every byte 0xE5) to Rt on port 0 only, and keeps the normal base writeback. The overlap decision takes precedence over the alignment check, and the class decode takes precedence over both.
- R9: `ins_ready` is high only while the block is idle. `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen, and each accepted instruction issues at most one request.
- R10: The vector writes and the base writeback are asserted together for exactly one cycle, in the cycle after the edge that samples `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_word | input | 32 | Instruction word |
| ins_ready | output | 1 | Block idle, instruction taken |
| big_endian | input | 1 | Half ordering select, sampled at acceptance |
| ovl_mode | input | 2 | Policy for Rt = Rt2, sampled at acceptance |
| gpr_raddr | output | 5 | General register read index (Rn of ins_word) |
| gpr_rdata | input | 64 | General register read data |
| sp_rdata | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address (32-byte access) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 256 | Read data |
| vwr0_en | output | 1 | Port 0 vector write enable |
| vwr0_idx | output | 5 | Port 0 register index (Rt) |
| vwr0_data | output | 128 | Port 0 write data |
| vwr1_en | output | 1 | Port 1 vector write enable |
| vwr1_idx | output | 5 | Port 1 register index (Rt2) |
| vwr1_data | output | 128 | Port 1 write data |
| wb_en | output | 1 | Base writeback enable |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index (Rn) |
| wb_data | output | 64 | Updated base address |
| undef_o | output | 1 | Undefined instruction pulse |
| align_fault_o | output | 1 | Stack pointer alignment fault pulse |

## Verification
The bench drives the two offset extremes, 7'h40 (-1024) and 7'h3F (+1008). A design that extends the sign wrongly or scales by the wrong factor produces a request address that is far off.

Post-index is compared against pre-index with the same base. If the offset is applied at the wrong time, the request address and the writeback value come out equal when they should differ.

Several cases go through the stack pointer:
- Rn = 31 with an aligned stack pointer, where a design that read general register 31 loads from the wrong place.
- A misaligned stack pointer, where a missing check issues a request.
- Overlapping destinations under each of the three policies, where a wrong policy shows up as an extra request, a missing pulse or a second write port firing.

Random words that match none of the three class patterns must pulse undefined without touching memory. Random response delays and request stalls expose any address that moves while waiting, and any write that fires before the data arrives.

// File: rtl/pairld_pkg.sv
package pairld_pkg;

    localparam int IW        = 32;
    localparam int REG_W     = 5;
    localparam int IMM_W     = 7;
    localparam int OFF_SHIFT = 4;
    localparam int CLS_W     = 10;

    localparam logic [CLS_W-1:0] PAT_POST = 10'b1110110011;
    localparam logic [CLS_W-1:0] PAT_PRE  = 10'b1110110111;
    localparam logic [CLS_W-1:0] PAT_OFF  = 10'b1110110101;

    typedef enum logic [1:0] {
        CLS_POST = 2'd0,
        CLS_PRE  = 2'd1,
        CLS_OFF  = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        OVL_UNDEF = 2'd0,
        OVL_NOP   = 2'd1,
        OVL_FILL  = 2'd2,
        OVL_RSVD  = 2'd3
    } ovl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } st_e;

    typedef struct packed {
        cls_e             cls;
        logic [IMM_W-1:0] imm;
        logic [REG_W-1:0] rt2;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rt;
    } dec_t;

endpackage

// File: rtl/pairld_decode.sv
module pairld_decode
    import pairld_pkg::*;
(
    input  logic [IW-1:0] word_i,
    output dec_t          dec_o
);
    logic [CLS_W-1:0] top_bits;

    assign top_bits = word_i[IW-1 -: CLS_W];

    always_comb begin
        dec_o.imm = word_i[21:15];
        dec_o.rt2 = word_i[14:10];
        dec_o.rn  = word_i[9:5];
        dec_o.rt  = word_i[4:0];
        unique case (top_bits)
            PAT_POST: dec_o.cls = CLS_POST;
            PAT_PRE:  dec_o.cls = CLS_PRE;
            PAT_OFF:  dec_o.cls = CLS_OFF;
            default:  dec_o.cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/pairld_agen.sv
module pairld_agen
    import pairld_pkg::*;
#(
    parameter int AW = 64
) (
    input  cls_e             cls_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [AW-1:0]    base_i,
    output logic [AW-1:0]    acc_addr_o,
    output logic [AW-1:0]    upd_addr_o,
    output logic             upd_en_o
);
    localparam int EXT_W = AW - IMM_W;

    logic [AW-1:0] imm_sext;
    logic [AW-1:0] byte_off;
    logic [AW-1:0] summed;

    assign imm_sext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign byte_off   = imm_sext << OFF_SHIFT;
    assign summed     = base_i + byte_off;
    assign acc_addr_o = (cls_i == CLS_POST) ? base_i : summed;
    assign upd_addr_o = summed;
    assign upd_en_o   = (cls_i == CLS_POST) || (cls_i == CLS_PRE);
endmodule

// File: rtl/pairld_split.sv
module pairld_split #(
    parameter int           VW       = 128,
    parameter logic [VW-1:0] FILL_PAT = {(VW/8){8'hE5}}
) (
    input  logic [2*VW-1:0] data_i,
    input  logic            be_i,
    input  logic            fill_i,
    output logic [VW-1:0]   first_o,
    output logic [VW-1:0]   second_o
);
    logic [VW-1:0] lo_half;
    logic [VW-1:0] hi_half;

    assign lo_half = data_i[VW-1:0];
    assign hi_half = data_i[2*VW-1:VW];

    always_comb begin
        if (fill_i) begin
            first_o  = FILL_PAT;
            second_o = FILL_PAT;
        end else if (be_i) begin
            first_o  = hi_half;
            second_o = lo_half;
        end else begin
            first_o  = lo_half;
            second_o = hi_half;
        end
    end
endmodule

// File: rtl/pairld_seq.sv
module pairld_seq
    import pairld_pkg::*;
#(
    parameter int            AW        = 64,
    parameter int            VW        = 128,
    parameter int            ALIGN_LSB = 4,
    parameter logic [VW-1:0] FILL_PAT  = {(VW/8){8'hE5}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [IW-1:0]     ins_word,
    output logic              ins_ready,
    input  logic              big_endian,
    input  logic [1:0]        ovl_mode,
    output logic [REG_W-1:0]  gpr_raddr,
    input  logic [AW-1:0]     gpr_rdata,
    input  logic [AW-1:0]     sp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [2*VW-1:0]   mem_rsp_data,
    output logic              vwr0_en,
    output logic [REG_W-1:0]  vwr0_idx,
    output logic [VW-1:0]     vwr0_data,
    output logic              vwr1_en,
    output logic [REG_W-1:0]  vwr1_idx,
    output logic [VW-1:0]     vwr1_data,
    output logic              wb_en,
    output logic              wb_to_sp,
    output logic [REG_W-1:0]  wb_idx,
    output logic [AW-1:0]     wb_data,
    output logic              undef_o,
    output logic              align_fault_o
);
    localparam int               DW     = 2 * VW;
    localparam logic [REG_W-1:0] SP_IDX = {REG_W{1'b1}};

    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    acc_addr;
        logic [AW-1:0]    upd_addr;
        logic             upd_en;
        logic             use_sp;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rt2;
        logic             fill;
        logic             be;
        logic [DW-1:0]    data;
        logic             undef;
        logic             fault;
    } seq_t;

    seq_t q, d;

    dec_t          dec;
    logic [AW-1:0] base_val;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] upd_addr;
    logic          upd_en;
    logic          is_sp;
    logic          overlap;
    logic          misaligned;
    ovl_e          pol;
    logic [VW-1:0] first_half;
    logic [VW-1:0] second_half;

    pairld_decode u_dec (
        .word_i (ins_word),
        .dec_o  (dec)
    );

    assign gpr_raddr = dec.rn;
    assign is_sp     = (dec.rn == SP_IDX);
    assign base_val  = is_sp ? sp_rdata : gpr_rdata;
    assign overlap   = (dec.rt == dec.rt2);
    assign misaligned = is_sp && (sp_rdata[ALIGN_LSB-1:0] != '0);
    assign pol       = ovl_e'(ovl_mode);

    pairld_agen #(.AW(AW)) u_agen (
        .cls_i      (dec.cls),
        .imm_i      (dec.imm),
        .base_i     (base_val),
        .acc_addr_o (acc_addr),
        .upd_addr_o (upd_addr),
        .upd_en_o   (upd_en)
    );

    pairld_split #(.VW(VW), .FILL_PAT(FILL_PAT)) u_split (
        .data_i   (q.data),
        .be_i     (q.be),
        .fill_i   (q.fill),
        .first_o  (first_half),
        .second_o (second_half)
    );

    always_comb begin
        d       = q;
        d.undef = 1'b0;
        d.fault = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ins_valid) begin
                    if (dec.cls == CLS_NONE) begin
                        d.undef = 1'b1;
                    end else if (overlap && (pol == OVL_UNDEF || pol == OVL_RSVD)) begin
                        d.undef = 1'b1;
                    end else if (overlap && pol == OVL_NOP) begin
                        d.st = ST_IDLE;
                    end else if (misaligned) begin
                        d.fault = 1'b1;
                    end else begin
                        d.st       = ST_REQ;
                        d.acc_addr = acc_addr;
                        d.upd_addr = upd_addr;
                        d.upd_en   = upd_en;
                        d.use_sp   = is_sp;
                        d.rn       = dec.rn;
                        d.rt       = dec.rt;
                        d.rt2      = dec.rt2;
                        d.fill     = overlap;
                        d.be       = big_endian;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_WB;
                    d.data = mem_rsp_data;
                end
            end
            ST_WB: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ins_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = (q.st == ST_REQ);
    assign mem_req_addr  = q.acc_addr;
    assign vwr0_en       = (q.st == ST_WB);
    assign vwr0_idx      = q.rt;
    assign vwr0_data     = first_half;
    assign vwr1_en       = (q.st == ST_WB) && !q.fill;
    assign vwr1_idx      = q.rt2;
    assign vwr1_data     = second_half;
    assign wb_en         = (q.st == ST_WB) && q.upd_en;
    assign wb_to_sp      = q.use_sp;
    assign wb_idx        = q.rn;
    assign wb_data       = q.upd_addr;
    assign undef_o       = q.undef;
    assign align_fault_o = q.fault;
endmodule

// File: rtl/pairld_seq_chk.sv
module pairld_seq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ins_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          vwr0_en,
    input logic          vwr1_en,
    input logic          wb_en,
    input logic          wb_to_sp,
    input logic [4:0]    wb_idx,
    input logic          undef_o,
    input logic          align_fault_o
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ready |-> !mem_req_valid && !vwr0_en && !wb_en);

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vwr0_en |=> !vwr0_en && !vwr1_en && !wb_en);

    p_wr_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vwr0_en |-> $past(mem_rsp_valid));

    p_port1_with_port0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vwr1_en || wb_en) |-> vwr0_en);

    p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !mem_req_valid && !vwr0_en && !align_fault_o);

    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> !mem_req_valid && !vwr0_en);

    p_sp_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && wb_to_sp |-> wb_idx == 5'd31);
endmodule

bind pairld_seq pairld_seq_chk #(.AW(AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_ready     (ins_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .vwr0_en       (vwr0_en),
    .vwr1_en       (vwr1_en),
    .wb_en         (wb_en),
    .wb_to_sp      (wb_to_sp),
    .wb_idx        (wb_idx),
    .undef_o       (undef_o),
    .align_fault_o (align_fault_o)
);

// File: tb/pairld_seq_tb_top.sv
module pairld_seq_tb_top;
    localparam logic [127:0] FILL = {16{8'hE5}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ins_valid = 1'b0;
    logic [31:0]  ins_word = '0;
    logic         ins_ready;
    logic         big_endian = 1'b0;
    logic [1:0]   ovl_mode = 2'd0;
    logic [4:0]   gpr_raddr;
    logic [63:0]  gpr_rdata;
    logic [63:0]  sp_rdata = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_data = '0;
    logic         vwr0_en, vwr1_en, wb_en, wb_to_sp;
    logic [4:0]   vwr0_idx, vwr1_idx, wb_idx;
    logic [127:0] vwr0_data, vwr1_data;
    logic [63:0]  wb_data;
    logic         undef_o, align_fault_o;

    logic [63:0]  regs [32];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign gpr_rdata = regs[gpr_raddr];

    pairld_seq dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mdata(input logic [63:0] a);
        return {a ^ 64'h0123456789ABCDEF, ~a, a + 64'h1111, {a[31:0], a[63:32]}};
    endfunction

    function automatic logic [31:0] mk(input int cls, input logic [6:0] imm,
                                       input logic [4:0] rt2, input logic [4:0] rn, input logic [4:0] rt);
        logic [9:0] top;
        case (cls)
            0: top = 10'b1110110011;
            1: top = 10'b1110110111;
            default: top = 10'b1110110101;
        endcase
        return {top, imm, rt2, rn, rt};
    endfunction

    // outcome: 0 undefined, 1 no-op, 2 alignment fault, 3 load
    task automatic run_ins(input logic [31:0] w, input logic be, input logic [1:0] pol);
        int cls, outcome;
        logic [63:0] base, off, eaddr, upd;
        logic [255:0] md;
        logic [127:0] e0, e1;
        logic [4:0] rt, rt2, rn;
        bit ovl, upd_on;
        int n_req = 0, n_extra = 0, n_wb = 0, n_und = 0, n_flt = 0;
        int phase = 0, dly = 0;

        rt = w[4:0]; rt2 = w[14:10]; rn = w[9:5];
        case (w[31:22])
            10'b1110110011: cls = 0;
            10'b1110110111: cls = 1;
            10'b1110110101: cls = 2;
            default:        cls = 3;
        endcase
        ovl = (rt == rt2);
        base = (rn == 5'd31) ? sp_rdata : regs[rn];
        off = {{57{w[21]}}, w[21:15]} << 4;
        upd = base + off;
        eaddr = (cls == 0) ? base : upd;
        upd_on = (cls == 0 || cls == 1);
        if (cls == 3) outcome = 0;
        else if (ovl && (pol == 2'd0 || pol == 2'd3)) outcome = 0;
        else if (ovl && pol == 2'd1) outcome = 1;
        else if (rn == 5'd31 && sp_rdata[3:0] != 4'h0) outcome = 2;
        else outcome = 3;
        md = mdata(eaddr);
        if (ovl) begin e0 = FILL; e1 = '0; end
        else if (be) begin e0 = md[255:128]; e1 = md[127:0]; end
        else begin e0 = md[127:0]; e1 = md[255:128]; end

        @(negedge clk);
        chk(ins_ready == 1'b1, "R9 ready while idle", ins_ready, 1);
        ins_word = w; ins_valid = 1'b1; big_endian = be; ovl_mode = pol;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            ins_valid = 1'b0;
            mem_rsp_valid = 1'b0;
            if (undef_o) n_und++;
            if (align_fault_o) n_flt++;
            if (vwr0_en || vwr1_en || wb_en) begin
                n_wb++;
                chk(vwr0_en && vwr0_idx == rt && vwr0_data == e0, "R7 port0 write", {vwr0_idx, vwr0_data}, {rt, e0});
                chk(vwr1_en == !ovl, "R8 port1 enable", vwr1_en, !ovl);
                if (!ovl)
                    chk(vwr1_idx == rt2 && vwr1_data == e1, "R7 port1 write", {vwr1_idx, vwr1_data}, {rt2, e1});
                chk(wb_en == upd_on, "R4 writeback enable", wb_en, upd_on);
                if (upd_on) begin
                    chk(wb_data == upd, "R4 writeback value", wb_data, upd);
                    chk(wb_to_sp == (rn == 5'd31) && wb_idx == rn, "R5 writeback target", {wb_to_sp, wb_idx}, {rn == 5'd31, rn});
                end
            end
            case (phase)
                0: if (mem_req_valid) begin
                    if (n_req == 0) chk(mem_req_addr == eaddr, "R3 request address", mem_req_addr, eaddr);
                    else chk(mem_req_addr == eaddr, "R9 address held", mem_req_addr, eaddr);
                    n_req++;
                    if ($urandom_range(0, 2) == 0) begin
                        mem_req_ready = 1'b1; phase = 1; dly = $urandom_range(0, 3);
                    end
                end
                1: begin
                    mem_req_ready = 1'b0;
                    if (mem_req_valid) n_extra++;
                    if (dly == 0) begin
                        mem_rsp_valid = 1'b1; mem_rsp_data = md; phase = 2;
                    end else dly--;
                end
                default: if (mem_req_valid) n_extra++;
            endcase
        end
        chk(n_und == (outcome == 0 ? 1 : 0), "R1/R8 undefined pulse count", n_und, outcome == 0);
        chk(n_flt == (outcome == 2 ? 1 : 0), "R6 fault pulse count", n_flt, outcome == 2);
        chk((n_req > 0) == (outcome == 3) && n_extra == 0, "R9 request issued", n_req, outcome == 3);
        chk(n_wb == (outcome == 3 ? 1 : 0), "R10 write cycles", n_wb, outcome == 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = {$urandom(), $urandom()};
        regs[7] = 64'h0000_0000_0010_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(ins_ready && !mem_req_valid && !vwr0_en && !wb_en && !undef_o && !align_fault_o,
            "R9 reset state", {ins_ready, mem_req_valid, vwr0_en, wb_en}, 4'b1000);

        // R2 offset extremes, R3 pre/post/offset
        run_ins(mk(1, 7'h40, 5'd2, 5'd7, 5'd1), 1'b0, 2'd0);
        run_ins(mk(0, 7'h3F, 5'd2, 5'd7, 5'd1), 1'b0, 2'd0);
        run_ins(mk(2, 7'h3F, 5'd4, 5'd7, 5'd3), 1'b1, 2'd0);
        // R5 stack pointer aligned
        sp_rdata = 64'h0000_7FFF_FFF0_0000;
        run_ins(mk(1, 7'h7F, 5'd9, 5'd31, 5'd8), 1'b0, 2'd0);
        run_ins(mk(0, 7'h01, 5'd9, 5'd31, 5'd8), 1'b1, 2'd0);
        // R6 misaligned stack pointer
        sp_rdata = 64'h0000_7FFF_FFF0_0008;
        run_ins(mk(2, 7'h00, 5'd9, 5'd31, 5'd8), 1'b0, 2'd0);
        // R8 overlap precedence over alignment, each policy
        run_ins(mk(1, 7'h02, 5'd5, 5'd31, 5'd5), 1'b0, 2'd0);
        run_ins(mk(1, 7'h02, 5'd5, 5'd31, 5'd5), 1'b0, 2'd1);
        sp_rdata = 64'h0000_0000_0000_1000;
        run_ins(mk(0, 7'h02, 5'd5, 5'd31, 5'd5), 1'b1, 2'd2);
        run_ins(mk(2, 7'h02, 5'd6, 5'd3, 5'd6), 1'b0, 2'd3);
        // R1 unmatched words
        run_ins(32'h0000_0000, 1'b0, 2'd2);
        run_ins(32'hEC80_0000 | 32'h1234, 1'b0, 2'd2);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            logic [4:0] rt, rt2, rn;
            rt  = 5'($urandom_range(0, 31));
            rt2 = ($urandom_range(0, 7) == 0) ? rt : 5'($urandom_range(0, 31));
            rn  = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
            sp_rdata = {$urandom(), $urandom()} & (($urandom_range(0, 4) == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFF0);
            regs[rn] = {$urandom(), $urandom()};
            if ($urandom_range(0, 9) == 0) w = $urandom();
            else w = mk($urandom_range(0, 2), 7'($urandom()), rt2, rn, rt);
            run_ins(w, 1'($urandom()), 2'($urandom_range(0, 3)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule